// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB TFT panel that has no controller of its own. It runs a dot counter and a line counter. Each axis is divided into a sync pulse, a back porch, a display span and a front porch, and every section length is a parameter. From those counters the block drives active-low horizontal and vertical sync, a data-enable whose polarity is selectable, and two strobes that mark the start of a line and the start of a frame for an external address generator. One clock cycle of this block equals one dot.

Pixels enter as 16-bit RGB565 words on a valid/ready stream. The block pulls one pixel for each display dot. It widens each colour field to the panel field width by copying the field's top bits into the spare low bits. The block never waits for the source. If a display dot arrives and `pix_valid` is low, that dot is sent black and the raster keeps running, so the source must keep up. `pix_ready` is high only in cycles whose pixel is sent to the panel on the next cycle.

The refresh rate can be lowered while the panel runs. Software requests a number of extra lines, and these lengthen the vertical front porch from the next frame onward. A request that would push the line count above a parameter limit is refused. The block drives a grant signal that allows a host CPU to access frame memory only on lines outside the display span. It also reports what percentage of the frame those lines represent.

Top module: `rgb_panel_timing`

## Requirements
- R1: A line lasts H_PULSE+H_BACK+H_DISP+H_FRONT dots. `hsync_n` is low for the first H_PULSE dots of each line and high for the rest of the line.
- R2: A frame lasts V_PULSE+V_BACK+V_DISP+V_FRONT+E lines, where E is the extra-line count in force. `vsync_n` is low during the first V_PULSE lines and high for the rest of the frame.
- R3: `de` is at its active level only on display dots of display lines. With DE_ACTIVE_HIGH=1 the active level is 1; with DE_ACTIVE_HIGH=0 it is 0.
- R4: `pix_ready` is high exactly one cycle before each display dot appears on the outputs. A pixel taken with `pix_valid` high is the pixel shown on that dot. If `pix_valid` is low the dot is black, and the raster does not stall. Outside display dots the colour outputs are zero.
- R5: The red field is bits 15:11, green is bits 10:5 and blue is bits 4:0. Each field is placed at the top of a PANEL_BITS-wide output. The remaining low bits repeat the field's own bits starting from its most significant bit.
- R6: `cpu_grant` is 1 on every dot of lines outside the display span and 0 on display lines.
- R7: A pulse on `rate_req` with `rate_extra`=E is accepted when V_PULSE+V_BACK+V_DISP+V_FRONT+E does not exceed V_MAX_TOTAL. The new value takes effect from the first frame that starts after the current frame ends. The extra lines are added to the front porch.
- R8: A refused request sets `rate_err` on the next cycle and leaves the extra-line count unchanged. An accepted request clears `rate_err`.
- R9: `access_pct` equals floor(100 × (total lines − V_DISP) / total lines) for the frame being output. It holds the new value from the first dot of a frame onward. During reset it holds the value for E=0.
- R10: `line_start` pulses for one cycle on the first dot of every line. `frame_start` pulses for one cycle on the first dot of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Source holds a pixel |
| pix_ready | output | 1 | Pixel taken this cycle (display dot next) |
| pix_data | input | 16 | RGB565 pixel |
| rate_req | input | 1 | One-cycle request to load a new extra-line count |
| rate_extra | input | EXTRA_W | Requested extra blanking lines |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, polarity set by DE_ACTIVE_HIGH |
| panel_r | output | PANEL_BITS | Red field to panel |
| panel_g | output | PANEL_BITS | Green field to panel |
| panel_b | output | PANEL_BITS | Blue field to panel |
| line_start | output | 1 | First dot of a line |
| frame_start | output | 1 | First dot of a frame |
| cpu_grant | output | 1 | Host may access frame memory |
| rate_err | output | 1 | Last rate request was refused |
| access_pct | output | 7 | Host access share of the frame, percent |

## Verification
If the line counter is wrong, `vsync_n` and `cpu_grant` move on the next line edge. If the extra-line register is wrong, the error is not visible until the frame that should use it: `frame_start` arrives too early or too late, and `access_pct` shows the wrong value from that frame's first dot. A slip in the dot counter or the pixel stage appears within one line. The bench sees it as a pixel pulled in the wrong cycle or a colour that does not match the scoreboard. Refused requests are checked at the ports: `vsync_n` timing and `access_pct` must stay unchanged across the frames that follow.

// File: rtl/rgbt_pkg.sv
`timescale 1ns/1ps
package rgbt_pkg;
  typedef enum logic [1:0] {
    SEG_PULSE = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_DISP  = 2'd2,
    SEG_FRONT = 2'd3
  } seg_t;

  localparam int RGB_W   = 16;
  localparam int PCT_W   = 7;
  localparam int RED_W   = 5;
  localparam int GREEN_W = 6;
  localparam int BLUE_W  = 5;
endpackage

// File: rtl/rgbt_axis_seq.sv
`timescale 1ns/1ps
module rgbt_axis_seq
  import rgbt_pkg::*;
#(
  parameter int CW      = 8,
  parameter int N_PULSE = 2,
  parameter int N_BACK  = 3,
  parameter int N_DISP  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] pos,
  output seg_t          seg,
  output logic          wrap
);
  localparam logic [CW-1:0] END_PULSE = CW'(N_PULSE);
  localparam logic [CW-1:0] END_BACK  = CW'(N_PULSE + N_BACK);
  localparam logic [CW-1:0] END_DISP  = CW'(N_PULSE + N_BACK + N_DISP);

  logic [CW-1:0] pos_q;

  assign wrap = step && (pos_q == total - CW'(1));
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     pos_q <= '0;
    else if (wrap)  pos_q <= '0;
    else if (step)  pos_q <= pos_q + CW'(1);
  end

  always_comb begin
    if (pos_q < END_PULSE)     seg = SEG_PULSE;
    else if (pos_q < END_BACK) seg = SEG_BACK;
    else if (pos_q < END_DISP) seg = SEG_DISP;
    else                       seg = SEG_FRONT;
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < total); // R1
endmodule

// File: rtl/rgbt_rate_ctrl.sv
`timescale 1ns/1ps
module rgbt_rate_ctrl
  import rgbt_pkg::*;
#(
  parameter int VW     = 5,
  parameter int EW     = 6,
  parameter int V_BASE = 8,
  parameter int V_DISP = 4,
  parameter int V_MAX  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [EW-1:0]    req_extra,
  input  logic             frame_end,
  output logic [VW-1:0]    v_total,
  output logic             rate_err,
  output logic [PCT_W-1:0] access_pct
);
  localparam int SW  = ((VW > EW) ? VW : EW) + 1;
  localparam int NW  = VW + 7;
  localparam int PCT0 = ((V_BASE - V_DISP) * 100) / V_BASE;

  logic [EW-1:0]    pend_q, act_q;
  logic             err_q;
  logic [PCT_W-1:0] pct_q;
  logic [SW-1:0]    want_total;
  logic             over;
  logic [NW-1:0]    num, quo;

  assign want_total = SW'(V_BASE) + SW'(req_extra);
  assign over       = want_total > SW'(V_MAX);
  assign v_total    = VW'(V_BASE) + VW'(act_q);
  assign num        = NW'(v_total - VW'(V_DISP)) * NW'(100);
  assign quo        = num / NW'(v_total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      err_q  <= 1'b0;
      pct_q  <= PCT_W'(PCT0);
    end else begin
      if (req) begin
        err_q <= over;
        if (!over) pend_q <= req_extra;
      end
      if (frame_end) act_q <= pend_q;
      pct_q <= PCT_W'(quo);
    end
  end

  assign rate_err   = err_q;
  assign access_pct = pct_q;

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req && over) |=> rate_err); // R8
  AST_SWAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_q)); // R7
  AST_TOTAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    v_total <= VW'(V_MAX)); // R7
  AST_PCT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    access_pct <= PCT_W'(100)); // R9
endmodule

// File: rtl/rgbt_pix_stage.sv
`timescale 1ns/1ps
module rgbt_pix_stage
  import rgbt_pkg::*;
#(
  parameter int PB = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [RGB_W-1:0] pix_data,
  output logic [PB-1:0]    out_r,
  output logic [PB-1:0]    out_g,
  output logic [PB-1:0]    out_b
);
  logic [RED_W-1:0]   src_r;
  logic [GREEN_W-1:0] src_g;
  logic [BLUE_W-1:0]  src_b;
  logic [PB-1:0]      wide_r, wide_g, wide_b;
  logic [PB-1:0]      r_q, g_q, b_q;

  assign src_r = pix_data[15:11];
  assign src_g = pix_data[10:5];
  assign src_b = pix_data[4:0];
  assign pix_ready = take;

  generate
    if (PB > RED_W) begin : g_rb_fill
      assign wide_r = {src_r, src_r[RED_W-1 -: (PB-RED_W)]};
      assign wide_b = {src_b, src_b[BLUE_W-1 -: (PB-BLUE_W)]};
    end else begin : g_rb_same
      assign wide_r = PB'(src_r);
      assign wide_b = PB'(src_b);
    end
    if (PB > GREEN_W) begin : g_g_fill
      assign wide_g = {src_g, src_g[GREEN_W-1 -: (PB-GREEN_W)]};
    end else begin : g_g_same
      assign wide_g = PB'(src_g);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
      g_q <= '0;
      b_q <= '0;
    end else if (take && pix_valid) begin
      r_q <= wide_r;
      g_q <= wide_g;
      b_q <= wide_b;
    end else begin
      r_q <= '0;
      g_q <= '0;
      b_q <= '0;
    end
  end

  assign out_r = r_q;
  assign out_g = g_q;
  assign out_b = b_q;

  AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (out_r == '0 && out_g == '0 && out_b == '0)); // R4
endmodule

// File: rtl/rgb_panel_timing.sv
`timescale 1ns/1ps
module rgb_panel_timing
  import rgbt_pkg::*;
#(
  parameter int H_PULSE        = 2,
  parameter int H_BACK         = 3,
  parameter int H_DISP         = 8,
  parameter int H_FRONT        = 3,
  parameter int V_PULSE        = 1,
  parameter int V_BACK         = 2,
  parameter int V_DISP         = 4,
  parameter int V_FRONT        = 1,
  parameter int V_MAX_TOTAL    = 20,
  parameter int EXTRA_W        = 6,
  parameter int PANEL_BITS     = 6,
  parameter bit DE_ACTIVE_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_valid,
  output logic                  pix_ready,
  input  logic [15:0]           pix_data,
  input  logic                  rate_req,
  input  logic [EXTRA_W-1:0]    rate_extra,
  output logic                  hsync_n,
  output logic                  vsync_n,
  output logic                  de,
  output logic [PANEL_BITS-1:0] panel_r,
  output logic [PANEL_BITS-1:0] panel_g,
  output logic [PANEL_BITS-1:0] panel_b,
  output logic                  line_start,
  output logic                  frame_start,
  output logic                  cpu_grant,
  output logic                  rate_err,
  output logic [6:0]            access_pct
);
  localparam int H_TOTAL = H_PULSE + H_BACK + H_DISP + H_FRONT;
  localparam int V_BASE  = V_PULSE + V_BACK + V_DISP + V_FRONT;
  localparam int HW      = $clog2(H_TOTAL + 1);
  localparam int VW      = $clog2(V_MAX_TOTAL + 1);
  localparam logic DE_ON = DE_ACTIVE_HIGH;

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos, v_total;
  seg_t          h_seg, v_seg;
  logic          h_wrap, v_wrap, frame_end, in_disp;
  logic          hs_q, vs_q, de_q, ls_q, fs_q, gr_q;

  rgbt_axis_seq #(
    .CW(HW), .N_PULSE(H_PULSE), .N_BACK(H_BACK), .N_DISP(H_DISP)
  ) u_h_axis (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .total(HW'(H_TOTAL)),
    .pos(h_pos), .seg(h_seg), .wrap(h_wrap)
  );

  rgbt_axis_seq #(
    .CW(VW), .N_PULSE(V_PULSE), .N_BACK(V_BACK), .N_DISP(V_DISP)
  ) u_v_axis (
    .clk(clk), .rst_n(rst_n), .step(h_wrap), .total(v_total),
    .pos(v_pos), .seg(v_seg), .wrap(v_wrap)
  );

  assign frame_end = h_wrap && v_wrap;

  rgbt_rate_ctrl #(
    .VW(VW), .EW(EXTRA_W), .V_BASE(V_BASE), .V_DISP(V_DISP), .V_MAX(V_MAX_TOTAL)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .req(rate_req), .req_extra(rate_extra),
    .frame_end(frame_end), .v_total(v_total), .rate_err(rate_err),
    .access_pct(access_pct)
  );

  assign in_disp = (h_seg == SEG_DISP) && (v_seg == SEG_DISP);

  rgbt_pix_stage #(.PB(PANEL_BITS)) u_pix (
    .clk(clk), .rst_n(rst_n), .take(in_disp), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data),
    .out_r(panel_r), .out_g(panel_g), .out_b(panel_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      de_q <= ~DE_ON;
      ls_q <= 1'b0;
      fs_q <= 1'b0;
      gr_q <= 1'b0;
    end else begin
      hs_q <= (h_seg != SEG_PULSE);
      vs_q <= (v_seg != SEG_PULSE);
      de_q <= in_disp ? DE_ON : ~DE_ON;
      ls_q <= (h_pos == '0);
      fs_q <= (h_pos == '0) && (v_pos == '0);
      gr_q <= (v_seg != SEG_DISP);
    end
  end

  assign hsync_n     = hs_q;
  assign vsync_n     = vs_q;
  assign de          = de_q;
  assign line_start  = ls_q;
  assign frame_start = fs_q;
  assign cpu_grant   = gr_q;

  AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (de == DE_ON) |-> (hsync_n && vsync_n)); // R3
  AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant |-> (de != DE_ON)); // R6
  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start); // R10
  AST_FRAME_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!vsync_n && !hsync_n)); // R2
endmodule

// File: tb/rgb_panel_timing_bench.sv
`timescale 1ns/1ps
module rgb_panel_timing_bench;
  localparam int HP = 2, HB = 3, HD = 8, HF = 3;
  localparam int VP = 1, VB = 2, VD = 4, VF = 1;
  localparam int VMAX = 20;
  localparam int PB = 8;
  localparam int HT = HP + HB + HD + HF;
  localparam int VBASE = VP + VB + VD + VF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic pix_ready;
  logic [15:0] pix_data = '0;
  logic rate_req = 1'b0;
  logic [5:0] rate_extra = '0;
  logic hsync_n, vsync_n, de, line_start, frame_start, cpu_grant, rate_err;
  logic [PB-1:0] panel_r, panel_g, panel_b;
  logic [6:0] access_pct;

  always #2 clk = ~clk;

  rgb_panel_timing #(.PANEL_BITS(PB)) u_rgb_panel_timing (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .rate_req(rate_req), .rate_extra(rate_extra),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .panel_r(panel_r), .panel_g(panel_g), .panel_b(panel_b),
    .line_start(line_start), .frame_start(frame_start),
    .cpu_grant(cpu_grant), .rate_err(rate_err), .access_pct(access_pct)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit run = 0;
  int mh = 0, mv = 0, vtot = VBASE, pend = 0, frames = 0;
  logic [3*PB-1:0] sb_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (h=%0d v=%0d)", req, act, exp, mh, mv);
    end
  endtask

  function automatic logic [PB-1:0] widen(input logic [7:0] src, input int sw);
    logic [PB-1:0] o;
    for (int k = 0; k < PB; k++) o[PB-1-k] = src[sw-1-(k % sw)];
    return o;
  endfunction

  function automatic logic [3*PB-1:0] expect_px(input logic [15:0] d);
    return {widen({3'b0, d[15:11]}, 5), widen({2'b0, d[10:5]}, 6), widen({3'b0, d[4:0]}, 5)};
  endfunction

  // driver: pixel source with periodic gaps
  int drv_n = 0;
  always @(negedge clk) begin
    drv_n++;
    pix_valid <= (drv_n % 5) != 2;
    pix_data  <= 16'(drv_n * 40503 + 7);
  end

  // scoreboard push on each pulled pixel (R4, R5)
  always @(posedge clk) begin
    if (rst_n && pix_ready)
      sb_q.push_back(pix_valid ? expect_px(pix_data) : '0);
  end

  // monitor: raster model and pixel compare
  always @(negedge clk) begin
    if (run) begin
      chk("R1 hsync_n", 32'(hsync_n), 32'(mh >= HP));
      chk("R2 vsync_n", 32'(vsync_n), 32'(mv >= VP));
      chk("R3 de", 32'(de), 32'((mh >= HP+HB && mh < HP+HB+HD) && (mv >= VP+VB && mv < VP+VB+VD)));
      chk("R6 cpu_grant", 32'(cpu_grant), 32'(!(mv >= VP+VB && mv < VP+VB+VD)));
      chk("R10 line_start", 32'(line_start), 32'(mh == 0));
      chk("R10 frame_start", 32'(frame_start), 32'(mh == 0 && mv == 0));
      if (mh == 0 && mv == 0)
        chk("R9 access_pct", 32'(access_pct), 32'(((vtot - VD) * 100) / vtot));
      if (de) begin
        if (sb_q.size() == 0) chk("R4 pixel pulled", 0, 1);
        else chk("R5 colour", 32'({panel_r, panel_g, panel_b}), 32'(sb_q.pop_front()));
      end else if (mh < HP+HB || mh >= HP+HB+HD) begin
        chk("R4 black outside", 32'({panel_r, panel_g, panel_b}), 0);
      end
      mh++;
      if (mh == HT) begin
        mh = 0;
        if (mv == vtot - 1) begin
          mv = 0;
          vtot = VBASE + pend;
          frames++;
        end else mv++;
      end
    end
  end

  task automatic wait_display_line();
    do @(posedge clk); while (!(mv == VP + VB + 1 && mh == 2));
  endtask

  task automatic request(input int e, input bit ok);
    wait_display_line();
    #1 rate_req = 1'b1; rate_extra = 6'(e);
    @(posedge clk);
    #1 rate_req = 1'b0;
    @(negedge clk);
    chk(ok ? "R8 accept clears" : "R8 refuse sets", 32'(rate_err), 32'(!ok));
    if (ok) pend = e;
  endtask

  task automatic wait_frames(input int n);
    int f0;
    f0 = frames;
    while (frames < f0 + n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset hsync_n", 32'(hsync_n), 1);
    chk("R2 reset vsync_n", 32'(vsync_n), 1);
    chk("R3 reset de", 32'(de), 0);
    chk("R6 reset grant", 32'(cpu_grant), 0);
    chk("R8 reset err", 32'(rate_err), 0);
    chk("R9 reset pct", 32'(access_pct), 50);
    rst_n = 1'b1;
    @(posedge clk);
    run = 1;
    wait_frames(2);
    request(4, 1);           // R7: 12 lines, 66 percent
    wait_frames(3);
    request(13, 0);          // R8: 21 lines exceeds limit
    wait_frames(2);
    request(12, 1);          // R7 boundary: exactly 20 lines, 80 percent
    wait_frames(2);
    request(0, 1);           // back to base
    wait_frames(2);
    chk("R4 scoreboard drained", 32'(sb_q.size() <= 1), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule